// File: doc/BRIEF.md
# UART FIFO Trigger-Level Controller

This block keeps the transmit and receive byte queues of one UART channel, 32 entries each, and decodes a write-only FIFO control byte. From that byte it takes the queue enable, a self-clearing pointer clear for each queue, the choice between normal and DMA signalling, and the receive and transmit trigger codes. The two trigger tables are not the same, and the transmit code can be changed only while the enhanced-feature input is high.

The host pushes transmit bytes and pops receive bytes. The serial side pops transmit bytes and pushes receive bytes. The block raises a receive-data interrupt when the receive level reaches its trigger. It raises a transmit interrupt when the transmit level falls below its trigger after having exceeded it. It also raises that interrupt when the queue drains to empty without ever having gone above the trigger since the last interrupt. Two active-low ready pins tell a DMA engine or the host when to move data. In normal mode they report byte-present and queue-empty. In DMA mode they report trigger-or-timeout and space-free.

Top module: `uart_fifo_trig`

## Requirements
- R1: Control bit 0 is the queue enable. While it is 0, pushes to both queues are dropped, and the clear bits 1 and 2 have no effect in the same write.
- R2: A write with bits 0 and 1 both set empties the receive queue and clears its interrupt and overrun flag. A write with bits 0 and 2 both set empties the transmit queue and clears its interrupt. Neither clear touches the other queue, and a later write without the bit leaves the count alone.
- R3: With `enh_en_i`=1, receive code bits [7:6] 00/01/10/11 select levels 8/16/24/28. `rx_irq_o` is 1 exactly when the receive count is at or above the level, and it is updated at the same edge as the count.
- R4: With `enh_en_i`=1, transmit code bits [5:4] 00/01/10/11 select levels 16/8/24/30. A control write made while `enh_en_i`=0 leaves the stored transmit code unchanged.
- R5: While `enh_en_i`=0, both levels are 1.
- R6: `tx_irq_o` sets at the edge where the transmit count decreases to below the level, provided the count has exceeded the level since the last interrupt.
- R7: `tx_irq_o` sets when the transmit count drops from non-zero to 0 if the count has not exceeded the level since the last interrupt. It clears at any edge where the transmit count increases, and on a transmit clear.
- R8: With bit 3 = 0, `rxrdy_no` is 0 exactly when the receive count is non-zero, and `txrdy_no` is 0 exactly when the transmit count is 0.
- R9: With bit 3 = 1, `rxrdy_no` is 0 when the receive count is at or above its level, or when `rx_timeout_i`=1 and the count is non-zero. `txrdy_no` is 0 when the transmit count is below 32.
- R10: The counts run from 0 to 32. A push into a full queue is dropped. A receive push into a full queue sets `rx_overrun_o`, which holds until a receive clear.
- R11: Each queue returns bytes in push order on its read-data output, registered one edge after the pop. A pop of an empty queue leaves the read data and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte |
| enh_en_i | input | 1 | Enhanced-feature enable |
| tx_push_i | input | 1 | Host writes a transmit byte |
| tx_wdata_i | input | DATA_W | Transmit byte in |
| tx_pop_i | input | 1 | Serial side takes a transmit byte |
| tx_rdata_o | output | DATA_W | Transmit byte out |
| tx_count_o | output | CNT_W | Transmit level |
| rx_push_i | input | 1 | Serial side delivers a receive byte |
| rx_wdata_i | input | DATA_W | Receive byte in |
| rx_pop_i | input | 1 | Host reads a receive byte |
| rx_rdata_o | output | DATA_W | Receive byte out |
| rx_count_o | output | CNT_W | Receive level |
| rx_timeout_i | input | 1 | Character timeout from the receiver |
| rx_overrun_o | output | 1 | Sticky receive overrun |
| rx_irq_o | output | 1 | Receive-data interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |
| rxrdy_no | output | 1 | Receive ready, active low |
| txrdy_no | output | 1 | Transmit ready, active low |

## Verification
The counts, both interrupts, the overrun flag and both read-data outputs are registered, so each is due at the first rising edge after the stimulus. The ready pins are combinational from the registered counts, the stored mode and `rx_timeout_i`. The bench drives every stimulus just after a falling edge and samples at the next falling edge, one rising edge later. It compares against a model that applies the requirement rules to the same stimulus. The timeout input is set and sampled within a single low phase, so that result is checked without any edge in between.

// File: rtl/uft_pkg.sv
package uft_pkg;
  typedef logic [5:0] lvl_t;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_RXCLR = 1;
  localparam int unsigned CB_TXCLR = 2;
  localparam int unsigned CB_DMA   = 3;

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       dma;
    logic       en;
  } cfg_t;

  function automatic lvl_t rx_level(input logic [1:0] code);
    case (code)
      2'd0:    return lvl_t'(8);
      2'd1:    return lvl_t'(16);
      2'd2:    return lvl_t'(24);
      default: return lvl_t'(28);
    endcase
  endfunction

  function automatic lvl_t tx_level(input logic [1:0] code);
    case (code)
      2'd0:    return lvl_t'(16);
      2'd1:    return lvl_t'(8);
      2'd2:    return lvl_t'(24);
      default: return lvl_t'(30);
    endcase
  endfunction
endpackage

// File: rtl/uft_cfg.sv
module uft_cfg
  import uft_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       enh_en_i,
  output cfg_t       cfg_o,
  output logic       rx_clr_o,
  output logic       tx_clr_o,
  output lvl_t       rx_lvl_o,
  output lvl_t       tx_lvl_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q.en      <= wdata_i[CB_EN];
      cfg_q.dma     <= wdata_i[CB_DMA];
      cfg_q.rx_code <= wdata_i[7:6];
      if (enh_en_i) cfg_q.tx_code <= wdata_i[5:4];
    end
  end

  // clears are pulses: nothing is stored, so they read back as 0
  assign rx_clr_o = we_i && wdata_i[CB_EN] && wdata_i[CB_RXCLR];
  assign tx_clr_o = we_i && wdata_i[CB_EN] && wdata_i[CB_TXCLR];
  assign rx_lvl_o = enh_en_i ? rx_level(cfg_q.rx_code) : lvl_t'(1);
  assign tx_lvl_o = enh_en_i ? tx_level(cfg_q.tx_code) : lvl_t'(1);
  assign cfg_o    = cfg_q;

  a_r4_tx_code_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !enh_en_i) |=> $stable(cfg_q.tx_code));
endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cnt_nxt_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rdata_q;
  logic              push_ok, pop_ok;

  assign push_ok = en_i && push_i && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (clr_i)                 cnt_nxt_o = '0;
    else if (push_ok && !pop_ok) cnt_nxt_o = cnt_q + CNT_W'(1);
    else if (!push_ok && pop_ok) cnt_nxt_o = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + PTR_W'(1);
      if (pop_ok) begin
        rd_q    <= rd_q + PTR_W'(1);
        rdata_q <= mem_q[rd_q];
      end
      cnt_q <= cnt_nxt_o;
    end
  end

  assign rdata_o = rdata_q;
  assign count_o = cnt_q;

  a_r10_count_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clr_i && cnt_q == CNT_W'(DEPTH)) |=> cnt_q == CNT_W'(DEPTH));
  a_r11_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0) |=> $stable(rdata_o));
  a_r11_ptr_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PTR_W'(wr_q - rd_q) == cnt_q[PTR_W-1:0]);
  a_r2_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/uft_tx_irq.sv
module uft_tx_irq
  import uft_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  lvl_t             lvl_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] lvl;
  logic filled_q, irq_q, fire_fall, fire_empty;

  assign lvl        = CNT_W'(lvl_i);
  // fall below trigger after an above-trigger refill
  assign fire_fall  = filled_q && (nxt_i < lvl) && (nxt_i < cnt_i);
  // drained to empty without ever exceeding the trigger
  assign fire_empty = !filled_q && (nxt_i == '0) && (cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      filled_q <= 1'b0;
    end else if (clr_i) begin
      irq_q    <= 1'b0;
      filled_q <= 1'b0;
    end else begin
      if (fire_fall || fire_empty) irq_q <= 1'b1;
      else if (nxt_i > cnt_i)      irq_q <= 1'b0;
      if (fire_fall)               filled_q <= 1'b0;
      else if (nxt_i > lvl)        filled_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  a_r7_empty_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_i != '0 && nxt_i == '0) |=> irq_o);
  a_r7_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && nxt_i > cnt_i) |=> !irq_o);
  a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
  import uft_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              enh_en_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  output logic [CNT_W-1:0]  tx_count_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic [CNT_W-1:0]  rx_count_o,
  input  logic              rx_timeout_i,
  output logic              rx_overrun_o,
  output logic              rx_irq_o,
  output logic              tx_irq_o,
  output logic              rxrdy_no,
  output logic              txrdy_no
);
  cfg_t             cfg;
  logic             rx_clr, tx_clr;
  lvl_t             rx_lvl, tx_lvl;
  logic [CNT_W-1:0] rx_nxt, tx_nxt, rx_lvl_c;
  logic             rx_ovr_q, rx_irq_q;

  uft_cfg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i), .enh_en_i,
    .cfg_o(cfg), .rx_clr_o(rx_clr), .tx_clr_o(tx_clr),
    .rx_lvl_o(rx_lvl), .tx_lvl_o(tx_lvl)
  );

  uft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .en_i(cfg.en), .clr_i(tx_clr), .push_i(tx_push_i),
    .wdata_i(tx_wdata_i), .pop_i(tx_pop_i), .rdata_o(tx_rdata_o),
    .count_o(tx_count_o), .cnt_nxt_o(tx_nxt)
  );

  uft_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .en_i(cfg.en), .clr_i(rx_clr), .push_i(rx_push_i),
    .wdata_i(rx_wdata_i), .pop_i(rx_pop_i), .rdata_o(rx_rdata_o),
    .count_o(rx_count_o), .cnt_nxt_o(rx_nxt)
  );

  uft_tx_irq #(.CNT_W(CNT_W)) u_tx_irq (
    .clk_i, .rst_ni, .clr_i(tx_clr), .lvl_i(tx_lvl),
    .cnt_i(tx_count_o), .nxt_i(tx_nxt), .irq_o(tx_irq_o)
  );

  assign rx_lvl_c = CNT_W'(rx_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_ovr_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else if (rx_clr) begin
      rx_ovr_q <= 1'b0;
      rx_irq_q <= 1'b0;
    end else begin
      if (cfg.en && rx_push_i && rx_count_o == CNT_W'(DEPTH)) rx_ovr_q <= 1'b1;
      rx_irq_q <= (rx_nxt >= rx_lvl_c);
    end
  end

  assign rx_overrun_o = rx_ovr_q;
  assign rx_irq_o     = rx_irq_q;

  always_comb begin
    if (cfg.dma) begin
      rxrdy_no = !((rx_count_o >= rx_lvl_c) || (rx_timeout_i && rx_count_o != '0));
      txrdy_no = (tx_count_o == CNT_W'(DEPTH));
    end else begin
      rxrdy_no = (rx_count_o == '0);
      txrdy_no = (tx_count_o != '0);
    end
  end

  a_r1_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.en && !rx_pop_i && !cfg_we_i) |=> $stable(rx_count_o));
  a_r10_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overrun_o && !rx_clr) |=> rx_overrun_o);
  a_r2_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> (!rx_overrun_o && !rx_irq_o));
  a_r2_tx_clear_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_clr && !rx_clr && !rx_push_i && !rx_pop_i) |=> $stable(rx_count_o));
endmodule

// File: tb/uart_fifo_trig_bench.sv
module uart_fifo_trig_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 0, enh = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, tmo = 0;
  logic [7:0] cfg_wd = '0, tx_wd = '0, rx_wd = '0;
  logic [7:0] tx_rd, rx_rd;
  logic [5:0] tx_cnt, rx_cnt;
  logic rx_ovr, rx_irq, tx_irq, rxrdy_n, txrdy_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fifo_trig u_uart_fifo_trig (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .enh_en_i(enh),
    .tx_push_i(tx_push), .tx_wdata_i(tx_wd), .tx_pop_i(tx_pop), .tx_rdata_o(tx_rd),
    .tx_count_o(tx_cnt), .rx_push_i(rx_push), .rx_wdata_i(rx_wd), .rx_pop_i(rx_pop),
    .rx_rdata_o(rx_rd), .rx_count_o(rx_cnt), .rx_timeout_i(tmo), .rx_overrun_o(rx_ovr),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq), .rxrdy_no(rxrdy_n), .txrdy_no(txrdy_n)
  );

  int n_chk = 0, n_err = 0;
  int rtab[4] = '{8, 16, 24, 28};
  int ttab[4] = '{16, 8, 24, 30};
  int tc = 0, rc = 0, rx_code = 0, tx_code = 0;
  bit m_en = 0, m_dma = 0, filled = 0, tirq = 0, rirq = 0, rovr = 0;
  logic [7:0] tseq = 8'h10, rseq = 8'h80, exp_td = '0, exp_rd = '0;
  logic [7:0] tq[$], rq[$];

  function automatic int rlvl();
    return enh ? rtab[rx_code] : 1;
  endfunction
  function automatic int tlvl();
    return enh ? ttab[tx_code] : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R10 tx count", tx_cnt, tc);
    chk("R10 rx count", rx_cnt, rc);
    chk("R10 rx overrun", rx_ovr, rovr);
    chk("R3 rx irq", rx_irq, rirq);
    chk("R6 tx irq", tx_irq, tirq);
    if (m_dma) begin
      chk("R9 rxrdy", rxrdy_n, !(rc >= rlvl() || (tmo && rc > 0)));
      chk("R9 txrdy", txrdy_n, tc == 32);
    end else begin
      chk("R8 rxrdy", rxrdy_n, rc == 0);
      chk("R8 txrdy", txrdy_n, tc != 0);
    end
    chk("R11 tx data", tx_rd, exp_td);
    chk("R11 rx data", rx_rd, exp_rd);
  endtask

  task automatic cfg_wr(input logic [7:0] d);
    cfg_we = 1; cfg_wd = d;
    @(posedge clk);
    if (d[0] && d[1]) begin rc = 0; rq.delete(); rovr = 0; rirq = 0; end
    else rirq = (rc >= rlvl());
    if (d[0] && d[2]) begin tc = 0; tq.delete(); tirq = 0; filled = 0; end
    else if (tc > tlvl()) filled = 1;
    m_en = d[0]; m_dma = d[3]; rx_code = d[7:6];
    if (enh) tx_code = d[5:4];
    @(negedge clk);
    cfg_we = 0;
    check_all();
  endtask

  task automatic cyc(input bit tp, input bit tpo_i, input bit rp, input bit rpo_i);
    int tn, rn, tl;
    bit tpa, tpo, rpa, rpo, fa, fb;
    tx_push = tp; tx_pop = tpo_i; tx_wd = tseq;
    rx_push = rp; rx_pop = rpo_i; rx_wd = rseq;
    @(posedge clk);
    tl  = tlvl();
    tpa = tp && m_en && tc < 32;
    tpo = tpo_i && tc > 0;
    tn  = tc + int'(tpa) - int'(tpo);
    if (tpo) exp_td = tq.pop_front();
    if (tpa) tq.push_back(tseq);
    fa = filled && tn < tl && tn < tc;
    fb = !filled && tn == 0 && tc != 0;
    if (fa || fb) tirq = 1; else if (tn > tc) tirq = 0;
    if (fa) filled = 0; else if (tn > tl) filled = 1;
    tc = tn;
    rpa = rp && m_en && rc < 32;
    if (rp && m_en && rc == 32) rovr = 1;
    rpo = rpo_i && rc > 0;
    rn  = rc + int'(rpa) - int'(rpo);
    if (rpo) exp_rd = rq.pop_front();
    if (rpa) rq.push_back(rseq);
    rirq = (rn >= rlvl());
    rc = rn;
    tseq = tseq + 8'd1; rseq = rseq + 8'd3;
    @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    check_all();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check_all();                                  // reset state, R8 pins

    // R1: disabled queues drop pushes
    cyc(1, 0, 1, 0);
    chk("R1 disabled tx push", tx_cnt, 0);
    enh = 1;
    cfg_wr(8'h07);
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0);
    cfg_wr(8'h06);                                // clears without enable
    chk("R1 clear ignored while disabled", rx_cnt, 3);
    cyc(1, 0, 1, 0);
    chk("R1 push dropped while disabled", tx_cnt, 3);
    cfg_wr(8'h01);

    // R2: per-queue clears, self-clearing
    cfg_wr(8'h03);
    chk("R2 rx cleared", rx_cnt, 0);
    chk("R2 tx untouched", tx_cnt, 3);
    cyc(0, 0, 1, 0);
    cfg_wr(8'h01);
    chk("R2 no repeat clear", rx_cnt, 1);
    cfg_wr(8'h05);
    chk("R2 tx cleared", tx_cnt, 0);
    chk("R2 rx untouched", rx_cnt, 1);

    // R3/R5/R8/R10/R11: receive sweep, all codes, enhanced off and on
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 4; c++) begin
        enh = e[0];
        cfg_wr({2'(c), 2'b00, 1'b0, 3'b111});
        for (int i = 0; i < 33; i++) begin
          cyc(0, 0, 1, 0);
          if (e == 0 && i == 0) chk("R5 rx irq at one byte", rx_irq, 1);
        end
        for (int i = 0; i < 34; i++) cyc(0, 0, 0, 1);
      end
    end

    // R9: receive DMA signalling with timeout
    for (int c = 0; c < 4; c++) begin
      enh = 1;
      cfg_wr({2'(c), 2'b00, 1'b1, 3'b111});
      cyc(0, 0, 1, 0);
      tmo = 1; #1;
      chk("R9 rxrdy on timeout", rxrdy_n, 0);
      tmo = 0; #1;
      chk("R9 rxrdy no timeout", rxrdy_n, 1);
      for (int i = 0; i < 29; i++) cyc(0, 0, 1, 0);
    end

    // R4/R5/R6/R7: transmit sweep
    for (int e = 0; e < 2; e++) begin
      for (int c = 0; c < 4; c++) begin
        int l;
        enh = e[0];
        cfg_wr({2'b00, 2'(c), 1'b0, 3'b111});
        l = tlvl();
        for (int i = 0; i < l + 2; i++) cyc(1, 0, 0, 0);
        for (int i = 0; i < l + 2; i++) cyc(0, 1, 0, 0);
        chk("R6 irq after fall", tx_irq, 1);
        cyc(1, 0, 0, 0);
        chk("R7 push clears irq", tx_irq, 0);
        cyc(0, 1, 0, 0);
        chk("R7 empty fires irq", tx_irq, 1);
        cyc(0, 1, 0, 0);
        cfg_wr({2'b00, 2'(c), 4'b0101});
        chk("R7 clear drops irq", tx_irq, 0);
      end
    end

    // R4: transmit code write blocked while enhanced features off
    enh = 1;
    cfg_wr({2'b00, 2'b11, 4'b0111});
    enh = 0;
    cfg_wr({2'b00, 2'b01, 4'b0001});
    enh = 1;
    for (int i = 0; i < 31; i++) cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    chk("R4 level 30 kept, count 30", tx_irq, 0);
    cyc(0, 1, 0, 0);
    chk("R4 level 30 kept, count 29", tx_irq, 1);

    // R9: transmit DMA space signalling
    cfg_wr({2'b00, 2'b00, 4'b1111});
    for (int i = 0; i < 33; i++) cyc(1, 0, 0, 0);
    chk("R9 txrdy high when full", txrdy_n, 1);

    finish_run();
  end
endmodule